// File: doc/BRIEF.md
# Tiled Histogram Equalizer

This block equalizes a stream of 8-bit brightness samples, one pixel per clock, by mapping each sample through the cumulative distribution of the square tile it falls in. The frame (640×480 by default) is cut into 100-pixel square tiles, giving a 7×5 grid. Tiles on the right and bottom edges are cut short by the frame border.

While a frame streams in, the block counts a 64-bin histogram for every tile. It also maps each pixel through the cumulative tables that the previous complete frame produced. Histograms are gathered one row band of tiles at a time. All tile columns of a band count in parallel. In the line blanking after a band's last row, each column runs a prefix sum over its 64 bins and writes the result into table memory. The table memory has two banks, and the block swaps them at the next start of frame. No frame buffer is needed, at the cost of one frame of lag.

The input marks the first pixel of a frame with `vin_sof` and the last pixel of each line with `vin_eol`. Until one full frame has been tabulated after reset, pixels pass through unchanged.

Top module: `tile_hist_eq`

## Requirements
- R1: An equalized pixel with brightness v in tile (column/TILE, row/TILE) is output as floor(C·255 / N). C is the number of pixels of that same tile in the previous complete frame whose bin is less than or equal to v's bin. N is the tile's in-frame area. Edge tiles use the width and height that remain inside the frame.
- R2: From reset until the first frame has been fully tabulated and a following start of frame has arrived, each output equals its input pixel unchanged.
- R3: The tables used for mapping change only on a pixel flagged as start of frame. From that pixel on, they are the tables of the frame that just ended, so every frame is mapped with the statistics of the frame before it.
- R4: The histogram bin of a pixel is its upper six bits, V[7:2]. Pixels that differ only in V[1:0] and share a tile map to the same output.
- R5: `vout_valid` repeats `vin_valid` exactly two clock cycles later, giving one output per accepted pixel in input order.
- R6: If a start of frame arrives before every band of the current frame has been tabulated, the tables are not swapped, and the older complete tables stay in use. Histogram counting restarts from zero at that start of frame.
- R7: After reset, `vout_valid` is low and the block is in pass-through mode.
- R8: A band's tables are built during the 64 cycles that follow the `vin_eol` of its last row, and `vin_valid` must stay low during those cycles. With exactly that minimum gap, the tables that are built are still correct.
- R9: A cycle with `vin_valid` low neither advances the column or row position nor adds anything to a histogram.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vin_valid | input | 1 | Input pixel present this cycle |
| vin_sof | input | 1 | Qualifies the first pixel of a frame |
| vin_eol | input | 1 | Qualifies the last pixel of a line |
| vin | input | DW (8) | Input brightness |
| vout_valid | output | 1 | Output pixel present this cycle |
| vout | output | DW (8) | Equalized brightness, 0 to 255 |

## Verification
The hardest cases to reach from the ports involve table history. One is a frame abandoned part-way, which must leave the older tables in use for the frame after it. The other is a band tabulated with exactly the minimum line gap. The stimulus first lays down two frames with different statistics, so that a wrong bank shows up in every output. It then streams a frame with the minimum 64-cycle gap and holes in its lines. Next comes a frame cut off one row into its second band, followed by complete frames. A behavioural model predicts every output from the tables of the frame it expects to be in use.

// File: rtl/theq_pkg.sv
package theq_pkg;

  // number of tiles needed to cover a dimension
  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  typedef enum logic {PASS_IDLE, PASS_RUN} theq_pass_e;

endpackage

// File: rtl/theq_locator.sv
// Tracks the tile position of the incoming pixel from sof/eol and running counters.
module theq_locator #(
  parameter int IMG_H = 480,
  parameter int TILE  = 100,
  parameter int TX    = 7,
  parameter int TY    = 5,
  parameter int TXW   = 3,
  parameter int TYW   = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           px_valid,
  input  logic           px_sof,
  input  logic           px_eol,
  output logic [TXW-1:0] pos_tx,
  output logic [TYW-1:0] pos_ty,
  output logic           band_done
);
  localparam int SW = (TILE > 1) ? $clog2(TILE) : 1;
  localparam int YW = $clog2(IMG_H + 1);

  logic [SW-1:0]  nsx, nsy, c_sx, c_sy;
  logic [TXW-1:0] ntx;
  logic [TYW-1:0] nty;
  logic [YW-1:0]  ny, c_y;
  logic           row_last;

  always_comb begin
    c_sx     = px_sof ? '0 : nsx;
    c_sy     = px_sof ? '0 : nsy;
    c_y      = px_sof ? '0 : ny;
    pos_tx   = px_sof ? '0 : ntx;
    pos_ty   = px_sof ? '0 : nty;
    row_last = (c_sy == SW'(TILE - 1)) || (c_y == YW'(IMG_H - 1));
    band_done = px_valid && px_eol && row_last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nsx <= '0; nsy <= '0; ntx <= '0; nty <= '0; ny <= '0;
    end else if (px_valid) begin
      if (px_eol) begin
        nsx <= '0;
        ntx <= '0;
        ny  <= c_y + 1'b1;
        if (row_last) begin
          nsy <= '0;
          nty <= (pos_ty == TYW'(TY - 1)) ? pos_ty : pos_ty + 1'b1;
        end else begin
          nsy <= c_sy + 1'b1;
          nty <= pos_ty;
        end
      end else begin
        if (c_sx == SW'(TILE - 1)) begin
          nsx <= '0;
          ntx <= (pos_tx == TXW'(TX - 1)) ? pos_tx : pos_tx + 1'b1;
        end else begin
          nsx <= c_sx + 1'b1;
          ntx <= pos_tx;
        end
        nsy <= c_sy;
        nty <= pos_ty;
        ny  <= c_y;
      end
    end
  end
endmodule

// File: rtl/theq_column.sv
// One tile column: histogram counters, prefix-sum accumulator and two-bank CDF table.
module theq_column #(
  parameter int BINS     = 64,
  parameter int BIN_BITS = 6,
  parameter int CNT_W    = 14,
  parameter int TY       = 5,
  parameter int TYW      = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                inc,
  input  logic [BIN_BITS-1:0] inc_bin,
  input  logic                pass_run,
  input  logic [BIN_BITS-1:0] pass_bin,
  input  logic [TYW-1:0]      pass_ty,
  input  logic                wr_bank,
  input  logic                rd_bank,
  input  logic [TYW-1:0]      rd_ty,
  input  logic [BIN_BITS-1:0] rd_bin,
  output logic [CNT_W-1:0]    rd_cdf
);
  localparam int DEPTH = 2 * TY * BINS;
  localparam int AW    = $clog2(DEPTH);

  logic [CNT_W-1:0] hist [BINS];
  logic [CNT_W-1:0] acc, acc_nx;
  logic [CNT_W-1:0] tbl [DEPTH];
  logic [AW-1:0]    wr_addr, rd_addr;

  always_comb begin
    acc_nx  = acc + hist[pass_bin];
    wr_addr = AW'((int'(wr_bank) * TY + int'(pass_ty)) * BINS + int'(pass_bin));
    rd_addr = AW'((int'(rd_bank) * TY + int'(rd_ty)) * BINS + int'(rd_bin));
  end

  // histogram: cleared at sof and bin by bin as the prefix pass consumes it
  always_ff @(posedge clk) begin
    for (int k = 0; k < BINS; k++) begin
      if (rst || clear || (pass_run && pass_bin == BIN_BITS'(k)))
        hist[k] <= '0;
    end
    if (!rst && inc)
      hist[inc_bin] <= (clear ? '0 : hist[inc_bin]) + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !pass_run) acc <= '0;
    else                  acc <= acc_nx;
  end

  // simple dual-port table, registered read
  always_ff @(posedge clk) begin
    if (pass_run) tbl[wr_addr] <= acc_nx;
    rd_cdf <= tbl[rd_addr];
  end
endmodule

// File: rtl/theq_scale.sv
// Output stage: CDF * max / tile area, or pass-through.
module theq_scale #(
  parameter int DW    = 8,
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_bypass,
  input  logic [DW-1:0]    in_v,
  input  logic [CNT_W-1:0] in_cdf,
  input  logic [CNT_W-1:0] in_cnt,
  output logic             out_valid,
  output logic [DW-1:0]    out_v
);
  localparam int PW = CNT_W + DW;
  localparam logic [DW-1:0] VMAX = {DW{1'b1}};

  logic [PW-1:0] prod, quot;
  logic [DW-1:0] mapped;

  always_comb begin
    prod   = PW'(in_cdf) * PW'(VMAX);
    quot   = (in_cnt == '0) ? '0 : prod / PW'(in_cnt);
    mapped = (quot > PW'(VMAX)) ? VMAX : quot[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_v     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_v <= in_bypass ? in_v : mapped;
    end
  end
endmodule

// File: rtl/tile_hist_eq.sv
module tile_hist_eq #(
  parameter int IMG_W = 640,
  parameter int IMG_H = 480,
  parameter int TILE  = 100,
  parameter int BINS  = 64,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vin_valid,
  input  logic          vin_sof,
  input  logic          vin_eol,
  input  logic [DW-1:0] vin,
  output logic          vout_valid,
  output logic [DW-1:0] vout
);
  localparam int TX       = theq_pkg::cdiv(IMG_W, TILE);
  localparam int TY       = theq_pkg::cdiv(IMG_H, TILE);
  localparam int TXW      = (TX > 1) ? $clog2(TX) : 1;
  localparam int TYW      = (TY > 1) ? $clog2(TY) : 1;
  localparam int BIN_BITS = $clog2(BINS);
  localparam int CNT_W    = $clog2(TILE * TILE + 1);
  localparam int LAST_W   = IMG_W - (TX - 1) * TILE;
  localparam int LAST_H   = IMG_H - (TY - 1) * TILE;
  localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(TILE * TILE);
  localparam logic [CNT_W-1:0] CNT_RIGHT = CNT_W'(LAST_W * TILE);
  localparam logic [CNT_W-1:0] CNT_BOT   = CNT_W'(TILE * LAST_H);
  localparam logic [CNT_W-1:0] CNT_CORN  = CNT_W'(LAST_W * LAST_H);

  logic [TXW-1:0]      cur_tx, s1_tx;
  logic [TYW-1:0]      cur_ty, pass_ty;
  logic                band_done;
  theq_pkg::theq_pass_e pass_state;
  logic [BIN_BITS-1:0] pass_bin, cur_bin;
  logic                pass_last, frame_done, wr_bank, tbl_ok;
  logic                sof_px, swap, eff_ok, eff_rd_bank, pass_busy;
  logic [CNT_W-1:0]    cur_cnt, s1_cnt;
  logic                s1_valid, s1_bypass;
  logic [DW-1:0]       s1_v;
  logic [CNT_W-1:0]    col_rd [TX];

  theq_locator #(
    .IMG_H(IMG_H), .TILE(TILE), .TX(TX), .TY(TY), .TXW(TXW), .TYW(TYW)
  ) u_loc (
    .clk(clk), .rst(rst), .px_valid(vin_valid), .px_sof(vin_sof), .px_eol(vin_eol),
    .pos_tx(cur_tx), .pos_ty(cur_ty), .band_done(band_done)
  );

  always_comb begin
    sof_px      = vin_valid && vin_sof;
    swap        = sof_px && frame_done;
    eff_ok      = swap ? 1'b1 : tbl_ok;
    eff_rd_bank = swap ? wr_bank : ~wr_bank;
    pass_busy   = (pass_state == theq_pkg::PASS_RUN);
    cur_bin     = vin[DW-1 -: BIN_BITS];
    case ({cur_tx == TXW'(TX - 1), cur_ty == TYW'(TY - 1)})
      2'b10:   cur_cnt = CNT_RIGHT;
      2'b01:   cur_cnt = CNT_BOT;
      2'b11:   cur_cnt = CNT_CORN;
      default: cur_cnt = CNT_FULL;
    endcase
  end

  // band prefix pass and table bank control
  always_ff @(posedge clk) begin
    if (rst) begin
      pass_state <= theq_pkg::PASS_IDLE;
      pass_bin   <= '0;
      pass_ty    <= '0;
      pass_last  <= 1'b0;
      frame_done <= 1'b0;
      wr_bank    <= 1'b0;
      tbl_ok     <= 1'b0;
    end else begin
      if (pass_busy) begin
        pass_bin <= pass_bin + 1'b1;
        if (pass_bin == BIN_BITS'(BINS - 1)) begin
          pass_state <= theq_pkg::PASS_IDLE;
          if (pass_last) frame_done <= 1'b1;
        end
      end
      if (band_done) begin
        pass_state <= theq_pkg::PASS_RUN;
        pass_bin   <= '0;
        pass_ty    <= cur_ty;
        pass_last  <= (cur_ty == TYW'(TY - 1));
      end
      if (sof_px) begin
        frame_done <= 1'b0;
        if (frame_done) begin
          wr_bank <= ~wr_bank;
          tbl_ok  <= 1'b1;
        end
      end
    end
  end

  for (genvar c = 0; c < TX; c++) begin : g_col
    theq_column #(
      .BINS(BINS), .BIN_BITS(BIN_BITS), .CNT_W(CNT_W), .TY(TY), .TYW(TYW)
    ) u_col (
      .clk(clk), .rst(rst), .clear(sof_px),
      .inc(vin_valid && (cur_tx == TXW'(c))), .inc_bin(cur_bin),
      .pass_run(pass_busy), .pass_bin(pass_bin), .pass_ty(pass_ty), .wr_bank(wr_bank),
      .rd_bank(eff_rd_bank), .rd_ty(cur_ty), .rd_bin(cur_bin), .rd_cdf(col_rd[c])
    );
  end

  // stage 1: aligned with the registered table read
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_v      <= '0;
      s1_bypass <= 1'b1;
      s1_tx     <= '0;
      s1_cnt    <= '0;
    end else begin
      s1_valid  <= vin_valid;
      s1_v      <= vin;
      s1_bypass <= ~eff_ok;
      s1_tx     <= cur_tx;
      s1_cnt    <= cur_cnt;
    end
  end

  theq_scale #(.DW(DW), .CNT_W(CNT_W)) u_scale (
    .clk(clk), .rst(rst), .in_valid(s1_valid), .in_bypass(s1_bypass), .in_v(s1_v),
    .in_cdf(col_rd[s1_tx]), .in_cnt(s1_cnt), .out_valid(vout_valid), .out_v(vout)
  );
endmodule

// File: rtl/theq_checker.sv
module theq_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          vin_valid,
  input logic          vin_sof,
  input logic [DW-1:0] vin,
  input logic          vout_valid,
  input logic [DW-1:0] vout,
  input logic          pass_busy,
  input logic          s1_bypass,
  input logic          wr_bank
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  AST_VALID_LAG: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2) |-> (vout_valid == $past(vin_valid, 2))); // R5

  AST_BYPASS_DATA: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && vout_valid && $past(s1_bypass)) |-> (vout == $past(vin, 2))); // R2

  AST_QUIET_IN_PASS: assert property (@(posedge clk) disable iff (rst)
    pass_busy |-> !vin_valid); // R8

  AST_SWAP_ON_SOF: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd1 && wr_bank != $past(wr_bank)) |-> $past(vin_valid && vin_sof)); // R3
endmodule

bind tile_hist_eq theq_checker #(.DW(DW)) u_theq_chk (
  .clk(clk), .rst(rst), .vin_valid(vin_valid), .vin_sof(vin_sof), .vin(vin),
  .vout_valid(vout_valid), .vout(vout), .pass_busy(pass_busy),
  .s1_bypass(s1_bypass), .wr_bank(wr_bank)
);

// File: tb/test_tile_hist_eq.sv
module test_tile_hist_eq;
  localparam int W   = 20;
  localparam int H   = 12;
  localparam int T   = 8;
  localparam int NB  = 64;
  localparam int TXB = (W + T - 1) / T;
  localparam int TYB = (H + T - 1) / T;
  localparam int NT  = TXB * TYB;
  localparam int LW  = W - (TXB - 1) * T;
  localparam int LH  = H - (TYB - 1) * T;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vin_valid = 1'b0, vin_sof = 1'b0, vin_eol = 1'b0;
  logic [7:0] vin = '0;
  logic vout_valid;
  logic [7:0] vout;

  always #2.5 clk = ~clk;

  tile_hist_eq #(.IMG_W(W), .IMG_H(H), .TILE(T), .BINS(NB), .DW(8)) i_tile_hist_eq (
    .clk(clk), .rst(rst), .vin_valid(vin_valid), .vin_sof(vin_sof), .vin_eol(vin_eol),
    .vin(vin), .vout_valid(vout_valid), .vout(vout)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  string tag = "R2";
  int due_q[$];
  int exp_q[$];
  string tag_q[$];
  int hist_cur [NT][NB];
  int cdf_prev [NT][NB];
  bit have_prev = 1'b0, cur_complete = 1'b0;

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      n_chk++;
      if (due_q.size() > 0 && due_q[0] == cyc) begin
        if (!vout_valid || vout != exp_q[0][7:0]) begin
          n_fail++;
          $display("FAIL %s: valid=%0d vout=%0d expected valid=1 vout=%0d",
                   tag_q[0], vout_valid, vout, exp_q[0]);
        end
        void'(due_q.pop_front());
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end else if (vout_valid) begin
        n_fail++;
        $display("FAIL R5: vout_valid=1 vout=%0d expected valid=0", vout);
      end
    end
  end

  function automatic int pix(int p, int x, int y);
    case (p)
      0: return (x * 13 + y * 7) & 255;
      1: return ((x * 37 + y * 91 + x * y * 11) ^ 8'h5a) & 255;
      2: return ((x * 53 + y * 29) ^ (x * y)) & 255;
      3: return (x + y) & 31;
      4: return 255 - ((x * 3 + y) & 15);
      default: return 240 + (x & 3) + 4 * ((x >> 2) & 3); // same bins, differing V[1:0]
    endcase
  endfunction

  task automatic push_px(int x, int y, int v, bit sof, bit eol);
    int t, b, cnt, e;
    t   = x / T + TXB * (y / T);
    b   = v >> 2;  // R4: bin is V[7:2]
    cnt = ((x / T == TXB - 1) ? LW : T) * ((y / T == TYB - 1) ? LH : T);
    if (sof) begin
      if (cur_complete) begin  // R3: swap to the frame just finished
        for (int k = 0; k < NT; k++) begin
          int run = 0;
          for (int j = 0; j < NB; j++) begin
            run += hist_cur[k][j];
            cdf_prev[k][j] = run;
          end
        end
        have_prev = 1'b1;
      end
      for (int k = 0; k < NT; k++)
        for (int j = 0; j < NB; j++) hist_cur[k][j] = 0;  // R6: restart counting
      cur_complete = 1'b0;
    end
    e = have_prev ? (cdf_prev[t][b] * 255) / cnt : v;  // R1 / R2
    hist_cur[t][b]++;
    @(negedge clk);
    vin_valid = 1'b1; vin = v[7:0]; vin_sof = sof; vin_eol = eol;
    due_q.push_back(cyc + 2);  // R5: two registers to the output
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      vin_valid = 1'b0; vin_sof = 1'b0; vin_eol = 1'b0;
    end
  endtask

  task automatic send_frame(int p, int rows, int gap, bit holes);
    for (int y = 0; y < rows; y++) begin
      for (int x = 0; x < W; x++) begin
        if (holes && (x == 5 || x == 13)) idle(1 + (y % 2));  // R9
        push_px(x, y, pix(p, x, y), (x == 0 && y == 0), (x == W - 1));
      end
      idle(gap);
    end
    if (rows == H) cur_complete = 1'b1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      n_chk++;
      if (vout_valid !== 1'b0) begin
        n_fail++;
        $display("FAIL R7: vout_valid=%0d after reset expected 0", vout_valid);
      end
    end
    tag = "R2"; send_frame(0, H, 66, 1'b0);   // no tables yet: pass-through
    tag = "R1"; send_frame(1, H, 66, 1'b0);   // mapped with frame 0
    tag = "R9"; send_frame(2, H, 64, 1'b1);   // R8 minimum gap, holes in lines
    tag = "R8"; send_frame(3, 9, 66, 1'b0);   // uses the min-gap tables; cut short
    tag = "R6"; send_frame(4, H, 66, 1'b0);   // aborted frame: older tables stay
    tag = "R4"; send_frame(5, H, 66, 1'b0);
    tag = "R3"; send_frame(0, H, 66, 1'b0);
    idle(10);
    if (due_q.size() != 0) begin
      n_fail++;
      $display("FAIL R5: %0d outputs missing expected 0", due_q.size());
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R5: watchdog expired, pending=%0d expected run to complete", due_q.size());
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule